// File: doc/BRIEF.md
# Reset Cause and Software Reset Controller

This block sits on a 32-bit register bus and manages reset status for a processor subsystem. It keeps a set of sticky flags that show which reset events have occurred. Software clears these flags through a separate write-one-to-clear register. Only a power-on reset returns the flags to their initial pattern.

Software can also request two kinds of reset, but only with a full-width write that carries a 16-bit key in the upper half. One request is a single-cycle CPU-only reset strobe. The other drives an active-low external-style reset output for a fixed number of clock cycles. A two-bit lock register holds bits that can only be set. Its outputs tell neighbouring register blocks to refuse writes, and only a system reset releases them.

Bus reads are registered: read data appears in the cycle after the read strobe. Writes take effect at the clock edge where they are sampled.

Top module: `rstctl_top`

## Requirements
- R1: After `por`, the cause register at word address 3 holds 0x003 in bits 11:0, the lock register at word address 0 reads 0, `ext_rst_n` is high and `cpu_rst_req` is low.
- R2: A write to the software-reset register (word address 1) acts only when all four byte enables are set and bits 31:16 equal 0xA5A5. A wrong key or a half-word write (enables 0011 or 1100) has no effect.
- R3: An accepted software-reset write with bit 0 set drives `cpu_rst_req` high for exactly the one cycle after the write edge, and sets cause bit 10.
- R4: An accepted software-reset write with bit 1 set drives `ext_rst_n` low for PULSE_LEN (default 512) consecutive cycles, starting in the cycle after the write edge, and sets cause bit 11. Writing 0 to bits 1:0 does nothing.
- R5: A new external-style request made while the pulse is running is ignored. It does not lengthen the pulse and does not set cause bit 11.
- R6: The cause flags are sticky and sit at fixed positions: bit 0 power-on, bit 1 pin reset (`evt_pin`), bit 2 watchdog (`evt_wd`), bit 3 NMI watchdog (`evt_nmiwd`), bit 8 security reset (`evt_sec`). `rst` does not clear them; only `por` does.
- R7: Cause bit 30 reads the live `pin_level` and bit 31 reads the live `dbg_conn`. All cause bits not named in R6, R3, R4 or here read 0.
- R8: A write to the clear register (word address 2) clears each cause flag whose bit is 1 in an enabled byte lane. Zero bits and disabled lanes have no effect, and the clear register always reads 0.
- R9: If a clear and a new event hit the same flag in the same cycle, the flag ends up set.
- R10: Lock bit 0 (`lock_all`) and lock bit 1 (`lock_patch`) can only be set by writing 1 (byte lane 0 enabled). Writing 0 leaves them unchanged, and `rst` or `por` clears them.
- R11: Reads of every register return their contents while the lock bits are set.
- R12: Unmapped word addresses and the software-reset register read 0, and writes to unmapped addresses change nothing.
- R13: `bus_rdata` carries the addressed value, as it was before the read edge, in the cycle after `bus_rd`; in other cycles it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | System reset, synchronous, active high (clears the lock bits) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_pin | input | 1 | Pin reset event pulse |
| evt_wd | input | 1 | Watchdog reset event pulse |
| evt_nmiwd | input | 1 | NMI watchdog reset event pulse |
| evt_sec | input | 1 | Security controller reset event pulse |
| pin_level | input | 1 | Live level of the reset pin |
| dbg_conn | input | 1 | Debugger connected flag |
| cpu_rst_req | output | 1 | Single-cycle CPU-only reset request |
| ext_rst_n | output | 1 | Active-low external-style reset pulse |
| lock_all | output | 1 | Lock for the general registers |
| lock_patch | output | 1 | Lock for the patch registers |

## Verification
Each result has a fixed due cycle after its stimulus:
- Write effects (flag updates, lock bits, the CPU strobe and the fall of `ext_rst_n`) are visible in the cycle after the sampling edge.
- Read data arrives one cycle after `bus_rd`.
- `ext_rst_n` rises again PULSE_LEN edges after it fell.

The bench drives stimulus on falling edges. A behavioural model advances at each rising edge, and every output is compared with the model at the next falling edge, so each check lands exactly in its due cycle. Directed checks count the pulse length with a falling-edge counter and read back flags right after each stimulus.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned CAUSE_W = 12;
  localparam int unsigned LOCK_W  = 2;
  localparam logic [15:0] SWRST_KEY = 16'hA5A5;

  // flag positions in the cause word
  localparam int unsigned F_POR    = 0;
  localparam int unsigned F_PIN    = 1;
  localparam int unsigned F_WD     = 2;
  localparam int unsigned F_NMIWD  = 3;
  localparam int unsigned F_SEC    = 8;
  localparam int unsigned F_SWCPU  = 10;
  localparam int unsigned F_SWEXT  = 11;
  localparam int unsigned F_PINLVL = 30;
  localparam int unsigned F_DBG    = 31;

  localparam logic [CAUSE_W-1:0] CAUSE_IMPL = 12'hD0F;
  localparam logic [CAUSE_W-1:0] CAUSE_INIT = 12'h003;

  function automatic logic [BUS_W-1:0] lane_bits(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/rstctl_cause.sv
module rstctl_cause #(
  parameter int unsigned WIDTH = 12,
  parameter logic [WIDTH-1:0] IMPL = '1,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             por,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flags_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_flag
    if (IMPL[i]) begin : g_impl
      logic flag_q;
      always_ff @(posedge clk) begin
        if (por) flag_q <= INIT[i];
        else     flag_q <= (flag_q & ~clr_i[i]) | set_i[i];
      end
      assign flags_o[i] = flag_q;
    end else begin : g_tie
      assign flags_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rstctl_swreset.sv
module rstctl_swreset #(
  parameter int unsigned PULSE_LEN = 512,
  parameter logic [15:0] KEY = 16'hA5A5
) (
  input  logic        clk,
  input  logic        por,
  input  logic        wr_i,
  input  logic        full_i,
  input  logic [15:0] key_i,
  input  logic [1:0]  cmd_i,
  output logic        cpu_req_o,
  output logic        ext_rst_n_o,
  output logic        cpu_fire_o,
  output logic        ext_fire_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             key_ok;

  assign key_ok     = wr_i && full_i && (key_i == KEY);
  assign cpu_fire_o = key_ok && cmd_i[0];
  assign ext_fire_o = key_ok && cmd_i[1] && (cnt_q == '0);

  always_comb begin
    if (ext_fire_o)         cnt_d = CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (por) begin
      cnt_q       <= '0;
      cpu_req_o   <= 1'b0;
      ext_rst_n_o <= 1'b1;
    end else begin
      cnt_q       <= cnt_d;
      cpu_req_o   <= cpu_fire_o;
      ext_rst_n_o <= (cnt_d == '0);
    end
  end
endmodule

// File: rtl/rstctl_lock.sv
module rstctl_lock #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] set_i,
  output logic [WIDTH-1:0] lock_o
);
  always_ff @(posedge clk) begin
    if (rst)       lock_o <= '0;
    else if (wr_i) lock_o <= lock_o | set_i;
  end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned PULSE_LEN  = 512,
  parameter int unsigned LOCK_ADDR  = 0,
  parameter int unsigned SWRST_ADDR = 1,
  parameter int unsigned CLR_ADDR   = 2,
  parameter int unsigned CAUSE_ADDR = 3
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_pin,
  input  logic              evt_wd,
  input  logic              evt_nmiwd,
  input  logic              evt_sec,
  input  logic              pin_level,
  input  logic              dbg_conn,
  output logic              cpu_rst_req,
  output logic              ext_rst_n,
  output logic              lock_all,
  output logic              lock_patch
);
  logic hit_lock, hit_swrst, hit_clr, hit_cause;
  assign hit_lock  = (bus_addr == ADDR_W'(LOCK_ADDR));
  assign hit_swrst = (bus_addr == ADDR_W'(SWRST_ADDR));
  assign hit_clr   = (bus_addr == ADDR_W'(CLR_ADDR));
  assign hit_cause = (bus_addr == ADDR_W'(CAUSE_ADDR));

  logic [CAUSE_W-1:0] clr_lanes;
  logic [LOCK_W-1:0]  lock_lanes;
  assign clr_lanes  = CAUSE_W'(lane_bits(bus_be));
  assign lock_lanes = LOCK_W'(lane_bits(bus_be));

  logic unused_wbits;
  assign unused_wbits = ^bus_wdata[15:CAUSE_W];

  // software reset requests
  logic sw_cpu_fire, sw_ext_fire;
  rstctl_swreset #(
    .PULSE_LEN (PULSE_LEN),
    .KEY       (SWRST_KEY)
  ) i_swreset (
    .clk         (clk),
    .por         (por),
    .wr_i        (bus_wr && hit_swrst),
    .full_i      (bus_be == 4'hF),
    .key_i       (bus_wdata[31:16]),
    .cmd_i       (bus_wdata[1:0]),
    .cpu_req_o   (cpu_rst_req),
    .ext_rst_n_o (ext_rst_n),
    .cpu_fire_o  (sw_cpu_fire),
    .ext_fire_o  (sw_ext_fire)
  );

  // sticky cause flags
  logic [CAUSE_W-1:0] cause_set, cause_clr, cause_flags;
  always_comb begin
    cause_set          = '0;
    cause_set[F_PIN]   = evt_pin;
    cause_set[F_WD]    = evt_wd;
    cause_set[F_NMIWD] = evt_nmiwd;
    cause_set[F_SEC]   = evt_sec;
    cause_set[F_SWCPU] = sw_cpu_fire;
    cause_set[F_SWEXT] = sw_ext_fire;
  end
  assign cause_clr = (bus_wr && hit_clr) ? (bus_wdata[CAUSE_W-1:0] & clr_lanes) : '0;

  rstctl_cause #(
    .WIDTH (CAUSE_W),
    .IMPL  (CAUSE_IMPL),
    .INIT  (CAUSE_INIT)
  ) i_cause (
    .clk     (clk),
    .por     (por),
    .set_i   (cause_set),
    .clr_i   (cause_clr),
    .flags_o (cause_flags)
  );

  // set-only lock bits
  logic [LOCK_W-1:0] lock_bits;
  rstctl_lock #(
    .WIDTH (LOCK_W)
  ) i_lock (
    .clk    (clk),
    .rst    (rst || por),
    .wr_i   (bus_wr && hit_lock),
    .set_i  (bus_wdata[LOCK_W-1:0] & lock_lanes),
    .lock_o (lock_bits)
  );
  assign lock_all   = lock_bits[0];
  assign lock_patch = lock_bits[1];

  // read path
  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (hit_lock) begin
      rd_word[LOCK_W-1:0] = lock_bits;
    end else if (hit_cause) begin
      rd_word[CAUSE_W-1:0] = cause_flags;
      rd_word[F_PINLVL]    = pin_level;
      rd_word[F_DBG]       = dbg_conn;
    end
  end

  always_ff @(posedge clk) begin
    if (por)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned PULSE_LEN  = 512,
  parameter int unsigned LOCK_ADDR  = 0,
  parameter int unsigned SWRST_ADDR = 1,
  parameter int unsigned CLR_ADDR   = 2,
  parameter int unsigned CAUSE_ADDR = 3
) (
  input logic              clk,
  input logic              por,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              cpu_rst_req,
  input logic              ext_rst_n,
  input logic              lock_all,
  input logic [11:0]       cause_flags
);
  localparam int unsigned RUN_W = $clog2(PULSE_LEN + 2);
  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (por)             low_run <= '0;
    else if (!ext_rst_n) low_run <= low_run + 1'b1;
    else                 low_run <= '0;
  end

  logic unmapped;
  assign unmapped = (bus_addr != ADDR_W'(LOCK_ADDR)) && (bus_addr != ADDR_W'(SWRST_ADDR)) &&
                    (bus_addr != ADDR_W'(CLR_ADDR))  && (bus_addr != ADDR_W'(CAUSE_ADDR));

  // R3
  cpu_single_cycle_chk: assert property (@(posedge clk) disable iff (por)
    cpu_rst_req |=> !cpu_rst_req);

  // R4
  ext_start_chk: assert property (@(posedge clk) disable iff (por)
    $fell(ext_rst_n) |-> $past(bus_wr && (bus_addr == ADDR_W'(SWRST_ADDR))));

  // R5
  ext_len_chk: assert property (@(posedge clk) disable iff (por)
    low_run <= RUN_W'(PULSE_LEN));

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (por)
    (lock_all && !rst) |=> lock_all);

  // R6
  por_flag_hold_chk: assert property (@(posedge clk) disable iff (por)
    (cause_flags[0] && !(bus_wr && (bus_addr == ADDR_W'(CLR_ADDR)))) |=> cause_flags[0]);

  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (por)
    (bus_rd && unmapped) |=> (bus_rdata == 32'h0));
endmodule

bind rstctl_top rstctl_chk #(
  .ADDR_W     (ADDR_W),
  .PULSE_LEN  (PULSE_LEN),
  .LOCK_ADDR  (LOCK_ADDR),
  .SWRST_ADDR (SWRST_ADDR),
  .CLR_ADDR   (CLR_ADDR),
  .CAUSE_ADDR (CAUSE_ADDR)
) i_chk (
  .clk         (clk),
  .por         (por),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .cpu_rst_req (cpu_rst_req),
  .ext_rst_n   (ext_rst_n),
  .lock_all    (lock_all),
  .cause_flags (cause_flags)
);

// File: tb/test_rstctl_top.sv
module test_rstctl_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 512;

  logic        clk = 1'b0;
  logic        por = 1'b1, rst = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_pin = 0, evt_wd = 0, evt_nmiwd = 0, evt_sec = 0;
  logic        pin_level = 1'b1, dbg_conn = 1'b0;
  logic        cpu_rst_req, ext_rst_n, lock_all, lock_patch;

  int checks = 0;
  int failures = 0;
  int low_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstctl_top i_rstctl_top (
    .clk(clk), .por(por), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pin(evt_pin), .evt_wd(evt_wd), .evt_nmiwd(evt_nmiwd), .evt_sec(evt_sec),
    .pin_level(pin_level), .dbg_conn(dbg_conn), .cpu_rst_req(cpu_rst_req),
    .ext_rst_n(ext_rst_n), .lock_all(lock_all), .lock_patch(lock_patch)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_cause, m_lock, m_rd;
  int          m_cnt;
  logic        m_ext_n, m_cpu, m_live = 1'b0;

  always @(posedge clk) begin
    logic [31:0] lanes, sets, clr;
    logic        sw_ok;
    if (por) begin
      m_cause = 32'h3; m_lock = 0; m_cnt = 0; m_ext_n = 1; m_cpu = 0; m_rd = 0;
    end else begin
      lanes = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
      if (bus_rd && bus_addr == 0)      m_rd = m_lock;
      else if (bus_rd && bus_addr == 3) m_rd = m_cause | {dbg_conn, pin_level, 30'b0};
      else                              m_rd = 0;
      sets = 0;
      if (evt_pin)   sets |= 32'h2;
      if (evt_wd)    sets |= 32'h4;
      if (evt_nmiwd) sets |= 32'h8;
      if (evt_sec)   sets |= 32'h100;
      sw_ok = bus_wr && bus_addr == 1 && bus_be == 4'hF && bus_wdata[31:16] == 16'hA5A5;
      m_cpu = sw_ok && bus_wdata[0];
      if (m_cpu) sets |= 32'h400;
      if (sw_ok && bus_wdata[1] && m_cnt == 0) begin
        m_cnt = PULSE; sets |= 32'h800;
      end else if (m_cnt > 0) m_cnt--;
      m_ext_n = (m_cnt == 0);
      clr = (bus_wr && bus_addr == 2) ? (bus_wdata & lanes & 32'hD0F) : 0;
      m_cause = (m_cause & ~clr) | sets;
      if (rst) m_lock = 0;
      else if (bus_wr && bus_addr == 0) m_lock |= bus_wdata & lanes & 32'h3;
    end
    m_live = 1'b1;
  end

  always @(negedge clk) begin
    if (m_live) begin
      check({31'b0, ext_rst_n}, {31'b0, m_ext_n}, "R4 ext_rst_n vs model");
      check({31'b0, cpu_rst_req}, {31'b0, m_cpu}, "R3 cpu_rst_req vs model");
      check({30'b0, lock_patch, lock_all}, m_lock, "R10 lock vs model");
      check(bus_rdata, m_rd, "R13 rdata vs model");
    end
    if (!ext_rst_n) low_cnt++;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk); bus_wr = 0; bus_be = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    check(bus_rdata, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por = 0;
    // R1 reset state
    check({31'b0, ext_rst_n}, 32'h1, "R1 ext_rst_n idle");
    check({31'b0, cpu_rst_req}, 32'h0, "R1 cpu_rst_req idle");
    rd(3, 32'h4000_0003, "R1 cause after por");
    rd(0, 32'h0, "R1 lock after por");
    // R7 live bits
    @(negedge clk); pin_level = 0; dbg_conn = 1;
    rd(3, 32'h8000_0003, "R7 live pin and debugger bits");
    rd(5, 32'h0, "R12 unmapped read");
    rd(1, 32'h0, "R12 swreset reads zero");
    // R6 events
    @(negedge clk); evt_wd = 1; @(negedge clk); evt_wd = 0;
    @(negedge clk); evt_nmiwd = 1; evt_sec = 1; @(negedge clk); evt_nmiwd = 0; evt_sec = 0;
    rd(3, 32'h8000_010F, "R6 event flags");
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    rd(3, 32'h8000_010F, "R6 flags survive rst");
    // R8 clear
    wr(2, 32'h4, 4'hF);
    rd(3, 32'h8000_010B, "R8 clear watchdog flag");
    wr(2, 32'h0, 4'hF);
    wr(2, 32'h1, 4'b1110);
    rd(3, 32'h8000_010B, "R8 zero and disabled lane ignored");
    rd(2, 32'h0, "R8 clear register reads zero");
    // R9 clear vs event
    @(negedge clk); bus_wr = 1; bus_addr = 2; bus_wdata = 32'h4; bus_be = 4'hF; evt_wd = 1;
    @(negedge clk); bus_wr = 0; bus_be = 0; evt_wd = 0;
    rd(3, 32'h8000_010F, "R9 event wins over clear");
    // R2 key and size gating
    wr(1, 32'h1234_0003, 4'hF);
    check({30'b0, cpu_rst_req, ext_rst_n}, 32'h1, "R2 wrong key ignored");
    wr(1, 32'hA5A5_0003, 4'b0011);
    check({30'b0, cpu_rst_req, ext_rst_n}, 32'h1, "R2 low half ignored");
    wr(1, 32'hA5A5_0003, 4'b1100);
    check({30'b0, cpu_rst_req, ext_rst_n}, 32'h1, "R2 high half ignored");
    wr(1, 32'hA5A5_0000, 4'hF);
    check({30'b0, cpu_rst_req, ext_rst_n}, 32'h1, "R4 zero bits do nothing");
    // R3 cpu reset
    wr(1, 32'hA5A5_0001, 4'hF);
    check({31'b0, cpu_rst_req}, 32'h1, "R3 strobe high");
    @(negedge clk);
    check({31'b0, cpu_rst_req}, 32'h0, "R3 strobe one cycle");
    rd(3, 32'h8000_050F, "R3 cause bit 10");
    // R4 / R5 external pulse
    low_cnt = 0;
    wr(1, 32'hA5A5_0002, 4'hF);
    check({31'b0, ext_rst_n}, 32'h0, "R4 pulse starts");
    repeat (5) @(negedge clk);
    wr(2, 32'h800, 4'hF);
    wr(1, 32'hA5A5_0002, 4'hF);
    repeat (600) @(negedge clk);
    check(low_cnt, PULSE, "R4 R5 pulse length");
    rd(3, 32'h8000_050F, "R5 re-request ignored");
    // R10 / R11 lock
    wr(0, 32'h1, 4'hF);
    check({30'b0, lock_patch, lock_all}, 32'h1, "R10 set lock_all");
    wr(0, 32'h0, 4'hF);
    check({30'b0, lock_patch, lock_all}, 32'h1, "R10 zero write no effect");
    wr(0, 32'hFFFF_FFFE, 4'hF);
    rd(0, 32'h3, "R11 lock readable while locked");
    rd(3, 32'h8000_050F, "R11 cause readable while locked");
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    check({30'b0, lock_patch, lock_all}, 32'h0, "R10 rst clears lock");
    rd(3, 32'h8000_050F, "R6 rst keeps cause");
    // R12 unmapped writes
    wr(7, 32'hFFFF_FFFF, 4'hF);
    rd(7, 32'h0, "R12 unmapped write ignored");
    rd(3, 32'h8000_050F, "R12 state unchanged");
    // R1 again
    @(negedge clk); por = 1; @(negedge clk); por = 0;
    rd(3, 32'h8000_0003, "R1 por restores cause");
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule